// File: doc/BRIEF.md
# Batch-Dispatch Interrupt Controller

This block decides when a small processor core must enter its interrupt handler, and it records what that handler has to service. Thirty-two request lines feed a pending register. The lowest three lines can also be raised by event sources inside the core. Pending lines that are not masked cause an entry request. The core accepts the request with an acknowledge pulse and presents its current program counter on the same cycle.

Acceptance is one atomic step. The program counter goes into a return-address register. Every unmasked pending line goes into a batch register, and those lines leave the pending register. One handler run therefore services the whole batch. While the handler runs, the end-of-interrupt output is high for exactly the batch lines. It drops when the core signals the return. Two scratch registers are also provided for the handler's use. They have no reset value.

The sequencer has two states. `ST_IDLE` is the reset state. It raises `entry_req` whenever an unmasked line is pending. It takes the transition *accept* to `ST_ACTIVE` when `entry_ack` arrives while `entry_req` is high. `ST_ACTIVE` drives `eoi` from the batch register. It takes the transition *return* back to `ST_IDLE` on `handler_ret`. With the build enable cleared, the pending logic is removed and the sequencer never leaves `ST_IDLE` with a request.

Top module: `batch_irq_ctrl`

## Requirements
- R1: After reset, `entry_req` is 0, `eoi` is 0, `ret_addr` and `batch_set` are 0, no line is pending and no line is masked.
- R2: A request bit held high for a single cycle on `irq_ext[n]` stays pending after the line drops. `entry_req` is high from the cycle after the line was sampled until the entry is accepted.
- R3: Bit k of `irq_int` (k = 0..2) requests line k exactly like `irq_ext[k]`. The two sources are ORed.
- R4: `entry_req` is high in `ST_IDLE` whenever at least one unmasked line is pending. On a clock edge with `entry_req` and `entry_ack` both high, `entry_pc` is stored into `ret_addr`.
- R5: On that accepting edge, `batch_set` takes the set of all unmasked pending lines, with bit n standing for line n. Several lines may be captured together.
- R6: In `ST_ACTIVE`, `eoi` equals `batch_set` and stays stable. After the edge that samples `handler_ret` high, `eoi` is 0.
- R7: No entry is requested while the handler runs, even if new lines become pending. If lines are pending, `entry_req` is high again in the first cycle after the return edge.
- R8: A pulse on `mask_we` loads `mask_din` into the mask, where bit n = 1 blocks line n. A blocked pending line never causes `entry_req` and is never captured. It stays pending, and it is dispatched once it is unmasked.
- R9: The accepting edge clears exactly the captured lines from the pending register. A request that arrives on that same edge stays pending and goes into the next batch.
- R10: `scr_we[0]` and `scr_we[1]` write `scr_din` into scratch registers `scratch0` and `scratch1`. These registers have no reset value.
- R11: With `ENABLE` = 0, `entry_req` is never raised and `eoi` stays 0, whatever the request inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_ext | input | NLINES | External request lines |
| irq_int | input | NINT | Core-internal event sources for lines 0..NINT-1 |
| mask_we | input | 1 | Mask write strobe |
| mask_din | input | NLINES | New mask value, 1 blocks a line |
| entry_req | output | 1 | Handler entry requested |
| entry_ack | input | 1 | Core accepts the entry |
| entry_pc | input | AW | Core program counter at acceptance |
| handler_ret | input | 1 | Handler return |
| ret_addr | output | AW | Saved return address |
| batch_set | output | NLINES | Lines captured at the last entry |
| eoi | output | NLINES | End-of-interrupt per line while the handler runs |
| scr_we | input | 2 | Scratch register write strobes |
| scr_din | input | AW | Scratch write data |
| scratch0 | output | AW | Scratch register 0 |
| scratch1 | output | AW | Scratch register 1 |

## Verification
The hardest case to reach is the same-edge race. A new request lands on the accepting edge, while the lines captured in that edge are being cleared. Its effect is hidden until the handler returns. The stimulus drives a fresh line in the acknowledge cycle and adds another line during the handler run. It then checks that `entry_req` comes back in the first cycle after the return and that the next batch holds both lines. The mask case is reached the same way: lines pend behind the mask and are released later.

// File: rtl/irq_batch_pkg.sv
package irq_batch_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } seq_state_t;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int NLINES = 32,
    parameter int NINT   = 3,
    parameter bit ENABLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irq_ext,
    input  logic [NINT-1:0]   irq_int,
    input  logic              mask_we,
    input  logic [NLINES-1:0] mask_din,
    input  logic              take,
    output logic [NLINES-1:0] armed,
    output logic [NLINES-1:0] mask_out
);
    // Fold the internal sources onto the lowest lines.
    logic [NLINES-1:0] int_vec;
    for (genvar k = 0; k < NLINES; k++) begin : g_fold
        if (k < NINT) begin : g_src
            assign int_vec[k] = irq_int[k];
        end else begin : g_none
            assign int_vec[k] = 1'b0;
        end
    end

    if (ENABLE) begin : g_on
        logic [NLINES-1:0] pend_q;
        logic [NLINES-1:0] mask_q;
        logic [NLINES-1:0] req_in;

        assign req_in   = irq_ext | int_vec;
        assign armed    = pend_q & ~mask_q;
        assign mask_out = mask_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q <= '0;
                mask_q <= '0;
            end else begin
                if (mask_we) begin
                    mask_q <= mask_din;
                end
                pend_q <= (pend_q & ~(take ? armed : '0)) | req_in;
            end
        end

        // R2: without an acceptance no pending bit is lost
        a_r2_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !take |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
        // R9: captured lines leave unless re-requested on the same edge
        a_r9_clear_taken: assert property (@(posedge clk) disable iff (!rst_n)
            take |=> ((pend_q & $past(armed) & ~$past(req_in)) == '0));
        // R8: lines blocked by the mask survive an acceptance
        a_r8_masked_kept: assert property (@(posedge clk) disable iff (!rst_n)
            take |=> ((pend_q & $past(pend_q & mask_q)) == $past(pend_q & mask_q)));
    end else begin : g_off
        logic unused_inputs;
        assign unused_inputs = ^{irq_ext, int_vec, mask_we, mask_din, take};
        assign armed    = '0;
        assign mask_out = '0;
    end
endmodule

// File: rtl/irq_dispatch_fsm.sv
module irq_dispatch_fsm
    import irq_batch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic armed_any,
    input  logic entry_ack,
    input  logic handler_ret,
    output logic entry_req,
    output logic take,
    output logic active
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (armed_any && entry_ack) state_d = ST_ACTIVE;
            ST_ACTIVE: if (handler_ret)            state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        entry_req = 1'b0;
        active    = 1'b0;
        unique case (state_q)
            ST_IDLE:   entry_req = armed_any;
            ST_ACTIVE: active    = 1'b1;
            default:   entry_req = 1'b0;
        endcase
        take = entry_req && entry_ack;
    end

    // R7: a return always brings the sequencer back to idle
    a_r7_ret_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (active && handler_ret) |=> !active);
    // R4: an accepted entry starts the handler
    a_r4_accept_enters: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (active && !entry_req));
endmodule

// File: rtl/irq_ctx_regs.sv
module irq_ctx_regs #(
    parameter int NLINES = 32,
    parameter int AW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [AW-1:0]     entry_pc,
    input  logic [NLINES-1:0] armed,
    input  logic [1:0]        scr_we,
    input  logic [AW-1:0]     scr_din,
    output logic [AW-1:0]     ret_addr,
    output logic [NLINES-1:0] batch_set,
    output logic [AW-1:0]     scratch0,
    output logic [AW-1:0]     scratch1
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_addr  <= '0;
            batch_set <= '0;
        end else if (take) begin
            ret_addr  <= entry_pc;
            batch_set <= armed;
        end
    end

    // Scratch storage has no reset by intent.
    always_ff @(posedge clk) begin
        if (scr_we[0]) scratch0 <= scr_din;
        if (scr_we[1]) scratch1 <= scr_din;
    end
endmodule

// File: rtl/batch_irq_ctrl.sv
module batch_irq_ctrl #(
    parameter int NLINES = 32,
    parameter int NINT   = 3,
    parameter int AW     = 32,
    parameter bit ENABLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irq_ext,
    input  logic [NINT-1:0]   irq_int,
    input  logic              mask_we,
    input  logic [NLINES-1:0] mask_din,
    output logic              entry_req,
    input  logic              entry_ack,
    input  logic [AW-1:0]     entry_pc,
    input  logic              handler_ret,
    output logic [AW-1:0]     ret_addr,
    output logic [NLINES-1:0] batch_set,
    output logic [NLINES-1:0] eoi,
    input  logic [1:0]        scr_we,
    input  logic [AW-1:0]     scr_din,
    output logic [AW-1:0]     scratch0,
    output logic [AW-1:0]     scratch1
);
    logic [NLINES-1:0] armed;
    logic [NLINES-1:0] mask_cur;
    logic              take;
    logic              active;

    irq_pend_bank #(.NLINES(NLINES), .NINT(NINT), .ENABLE(ENABLE)) u_pend (
        .clk(clk), .rst_n(rst_n), .irq_ext(irq_ext), .irq_int(irq_int),
        .mask_we(mask_we), .mask_din(mask_din), .take(take),
        .armed(armed), .mask_out(mask_cur)
    );

    irq_dispatch_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .armed_any(|armed), .entry_ack(entry_ack),
        .handler_ret(handler_ret), .entry_req(entry_req), .take(take),
        .active(active)
    );

    irq_ctx_regs #(.NLINES(NLINES), .AW(AW)) u_ctx (
        .clk(clk), .rst_n(rst_n), .take(take), .entry_pc(entry_pc),
        .armed(armed), .scr_we(scr_we), .scr_din(scr_din),
        .ret_addr(ret_addr), .batch_set(batch_set),
        .scratch0(scratch0), .scratch1(scratch1)
    );

    assign eoi = active ? batch_set : '0;

    // R5: the batch equals the unmasked pending set at acceptance
    a_r5_batch_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_req && entry_ack) |=> (batch_set == $past(armed)));
    // R4: the return address is the PC presented with the acknowledge
    a_r4_pc_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_req && entry_ack) |=> (ret_addr == $past(entry_pc)));
    // R8: a blocked line is never part of a batch
    a_r8_mask_excluded: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_req && entry_ack) |=> ((batch_set & $past(mask_cur)) == '0));
    // R6: end-of-interrupt holds during the handler and drops on return
    a_r6_eoi_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !handler_ret) |=> $stable(eoi));
    a_r6_eoi_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (active && handler_ret) |=> (eoi == '0));
    // R7: no entry request while the handler runs
    a_r7_no_req_active: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> !entry_req);

    if (!ENABLE) begin : g_off_chk
        // R11: a disabled build never requests entry
        a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            irq_ext != '0 |-> !entry_req);
    end
endmodule

// File: tb/sim_batch_irq_ctrl.sv
module sim_batch_irq_ctrl;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_ext = '0;
    logic [2:0]  irq_int = '0;
    logic        mask_we = 1'b0;
    logic [31:0] mask_din = '0;
    logic        entry_ack = 1'b0;
    logic [31:0] entry_pc = '0;
    logic        handler_ret = 1'b0;
    logic [1:0]  scr_we = '0;
    logic [31:0] scr_din = '0;

    logic        entry_req, u1_req;
    logic [31:0] ret_addr, batch_set, eoi, scratch0, scratch1;
    logic [31:0] u1_ra, u1_bs, u1_eoi, u1_s0, u1_s1;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    batch_irq_ctrl #(.ENABLE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_ext(irq_ext), .irq_int(irq_int),
        .mask_we(mask_we), .mask_din(mask_din), .entry_req(entry_req),
        .entry_ack(entry_ack), .entry_pc(entry_pc), .handler_ret(handler_ret),
        .ret_addr(ret_addr), .batch_set(batch_set), .eoi(eoi),
        .scr_we(scr_we), .scr_din(scr_din), .scratch0(scratch0), .scratch1(scratch1)
    );

    batch_irq_ctrl #(.ENABLE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .irq_ext(irq_ext), .irq_int(irq_int),
        .mask_we(mask_we), .mask_din(mask_din), .entry_req(u1_req),
        .entry_ack(entry_ack), .entry_pc(entry_pc), .handler_ret(handler_ret),
        .ret_addr(u1_ra), .batch_set(u1_bs), .eoi(u1_eoi),
        .scr_we(scr_we), .scr_din(scr_din), .scratch0(u1_s0), .scratch1(u1_s1)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    // One-cycle pulse on the external lines.
    task automatic pulse(input logic [31:0] v);
        irq_ext = v;
        cyc();
        irq_ext = '0;
    endtask

    // Accept an entry and check the captured context.
    task automatic accept(input logic [31:0] pc, input logic [31:0] exp_set, input string tag);
        check({tag, " R4 entry_req before ack"}, {31'd0, entry_req}, 32'd1);
        entry_ack = 1'b1;
        entry_pc  = pc;
        cyc();
        entry_ack = 1'b0;
        check({tag, " R4 ret_addr"}, ret_addr, pc);
        check({tag, " R5 batch_set"}, batch_set, exp_set);
        check({tag, " R6 eoi active"}, eoi, exp_set);
        check({tag, " R7 no req while active"}, {31'd0, entry_req}, 32'd0);
    endtask

    task automatic retire(input string tag);
        handler_ret = 1'b1;
        cyc();
        handler_ret = 1'b0;
        check({tag, " R6 eoi dropped"}, eoi, 32'd0);
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        check("R1 entry_req", {31'd0, entry_req}, 32'd0);
        check("R1 eoi", eoi, 32'd0);
        check("R1 ret_addr", ret_addr, 32'd0);
        check("R1 batch_set", batch_set, 32'd0);

        // R2, R4, R5, R6, R11: sweep every external line
        for (int n = 0; n < 32; n++) begin
            pulse(32'd1 << n);
            check("R2 req after pulse", {31'd0, entry_req}, 32'd1);
            check("R11 disabled quiet", {31'd0, u1_req}, 32'd0);
            cyc();
            check("R2 pending held", {31'd0, entry_req}, 32'd1);
            accept(32'h1000 + 32'(n) * 4, 32'd1 << n, "sweep");
            cyc();
            check("R6 eoi stable", eoi, 32'd1 << n);
            retire("sweep");
            check("R7 no req when nothing pends", {31'd0, entry_req}, 32'd0);
            check("R11 disabled eoi", u1_eoi, 32'd0);
        end

        // R3: internal sources one by one, then together with an external line
        for (int k = 0; k < 3; k++) begin
            irq_int = 3'(1 << k);
            cyc();
            irq_int = '0;
            accept(32'h2000 + 32'(k), 32'd1 << k, "R3 internal");
            retire("R3 internal");
        end
        irq_int = 3'b111;
        irq_ext = 32'h8000_0001;
        cyc();
        irq_int = '0;
        irq_ext = '0;
        accept(32'h2100, 32'h8000_0007, "R3 merged");
        retire("R3 merged");

        // R5: batches built from patterns sampled on consecutive cycles
        for (int p = 0; p < 8; p++) begin
            logic [31:0] a, b;
            a = 32'hA5A5_0F0F ^ (32'h0101_0101 << p);
            b = 32'h1234_5678 >> p;
            pulse(a);
            pulse(b);
            accept(32'h3000 + 32'(p), a | b, "R5 batch");
            retire("R5 batch");
        end

        // R7, R9: arrival on the accepting edge and during the handler
        pulse(32'h0000_0011);
        check("R9 req", {31'd0, entry_req}, 32'd1);
        irq_ext = 32'h0000_0022;
        entry_ack = 1'b1;
        entry_pc = 32'h4000;
        cyc();
        entry_ack = 1'b0;
        irq_ext = '0;
        check("R9 batch excludes same-edge arrival", batch_set, 32'h0000_0011);
        pulse(32'h0000_0400);
        check("R7 held off while active", {31'd0, entry_req}, 32'd0);
        cyc();
        check("R7 still held off", {31'd0, entry_req}, 32'd0);
        retire("R7");
        check("R7 req right after return", {31'd0, entry_req}, 32'd1);
        accept(32'h4100, 32'h0000_0422, "R9 next batch");
        retire("R9");

        // R8: masked lines pend but are not dispatched
        mask_we = 1'b1;
        mask_din = 32'hFFFF_0000;
        cyc();
        mask_we = 1'b0;
        pulse(32'h0003_0000);
        check("R8 masked no req", {31'd0, entry_req}, 32'd0);
        pulse(32'h0003_0001);
        accept(32'h5000, 32'h0000_0001, "R8 partial");
        retire("R8 partial");
        cyc();
        check("R8 masked still quiet", {31'd0, entry_req}, 32'd0);
        mask_we = 1'b1;
        mask_din = 32'h0;
        cyc();
        mask_we = 1'b0;
        accept(32'h5100, 32'h0003_0000, "R8 released");
        retire("R8 released");

        // R10: scratch registers
        scr_we = 2'b01;
        scr_din = 32'hDEAD_BEEF;
        cyc();
        scr_we = 2'b10;
        scr_din = 32'h1234_5678;
        cyc();
        scr_we = 2'b00;
        scr_din = 32'h0;
        cyc();
        check("R10 scratch0", scratch0, 32'hDEAD_BEEF);
        check("R10 scratch1", scratch1, 32'h1234_5678);

        check("R11 disabled final req", {31'd0, u1_req}, 32'd0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule